// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This peripheral holds a set of independent down-counters (six by default). Each channel has a control word, a reload interval and a live count value, all reached over a simple single-cycle register bus. When running, a channel picks one of two tick inputs, divides it by a power of two, and counts its live value down by one on each divided tick. When the count reaches zero the channel raises its pending flag. It can then load its interval and keep going, stop its own run bit, or simply rest at zero.

Two shared registers sit in front of the channels. An enable mask selects which pending flags may drive the single combined interrupt line. A status register shows the pending flags, and software clears a flag by writing a 1 to its bit. Because the live count can be written on its own, software can set the first timeout apart from the steady period.

The register bus has no handshake. A write is taken on the clock edge where `bus_wr` is high, and read data follows the address combinationally. The tick inputs are single-cycle enables in the block's clock domain.

Top module: `ivtimer`

## Requirements
- R1: After reset every readable register reads zero, no channel counts and `irq` is low.
- R2: Byte offset 0x00 is the interrupt enable mask and 0x04 the pending status, with bit n for channel n. Channel n's control word is at 0x10+0x10·n, its interval at 0x14+0x10·n and its live count at 0x18+0x10·n. Address bits 1:0 are ignored. Every other offset reads zero and ignores writes.
- R3: The control word reads back as written. Bit 0 is run, bit 1 is auto-reload, bits 3:2 are the tick source, bits 6:4 are the prescale exponent p, and bit 7 is single-shot mode (1) versus continuous (0).
- R4: A running channel sees one divided tick for every 2^p ticks of its source, counted from the last write of its control word. A live count of N with no reload therefore expires exactly N·2^p source ticks after that write.
- R5: Each divided tick lowers a nonzero live count by one. On the edge where the count leaves 1, the channel's pending bit becomes set, and only that channel's bit.
- R6: With auto-reload set, the expiring edge loads the interval into the live count, and counting goes on with a period of interval·2^p source ticks.
- R7: With auto-reload clear, the live count stays at zero after expiry and no further pending flag is raised.
- R8: In single-shot mode the expiring edge clears the channel's run bit. In continuous mode the run bit stays set.
- R9: While run is clear, or while the live count is zero, the live count holds and no expiry occurs.
- R10: Tick source code 0 selects no tick, code 1 selects `tick_main`, and codes 2 and 3 select `tick_alt`.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear of that bit leaves the bit set.
- R12: `irq` is high exactly when some channel is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr`, combinational |
| tick_main | input | 1 | Main reference tick enable (source code 1) |
| tick_alt | input | 1 | Alternate tick enable (source codes 2 and 3) |
| irq | output | 1 | Combined interrupt: OR of pending AND enabled |

## Verification
The hardware setting a pending bit and a software write-one-to-clear of that same bit can land on the same edge. The bench provokes this by timing a status write, with no source prescaling, so that its capturing edge is exactly the fifth divided tick of a channel loaded with 5. It then reads the status and expects the bit to still be set. A following write of zero must leave the bit set, and a later write of one must clear it. The expiry timing is swept across every channel and every prescale exponent and compared against N·2^p computed in the bench, so an off-by-one in either the divider or the counter shows up as a wrong cycle count.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  // Control word width and prescale exponent width.
  localparam int CTRL_W = 8;
  localparam int PSC_W  = 3;

  // Control word; bit 0 is the least significant member.
  typedef struct packed {
    logic             single;  // [7]   stop run bit on expiry
    logic [PSC_W-1:0] psc;     // [6:4] divide by 2^psc
    logic [1:0]       src;     // [3:2] tick source
    logic             autorl;  // [1]   reload from interval on expiry
    logic             run;     // [0]   counting enabled
  } ivt_ctrl_t;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_ALT0 = 2'd2,
    SRC_ALT1 = 2'd3
  } ivt_src_e;

  // Word field inside a 16-byte slot.
  localparam logic [1:0] FLD_CTRL = 2'd0;
  localparam logic [1:0] FLD_INTV = 2'd1;
  localparam logic [1:0] FLD_CUR  = 2'd2;
  localparam logic [1:0] GLB_EN   = 2'd0;
  localparam logic [1:0] GLB_STAT = 2'd1;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
  import ivt_pkg::*;
#(
  parameter int EXP_W = PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             src_tick,
  input  logic [EXP_W-1:0] shift,
  output logic             div_tick
);

  localparam int DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;

  // mask has shift ones at the bottom; the shift wraps cleanly at the top
  always_comb begin
    mask     = (DIV_W'(1) << shift) - DIV_W'(1);
    div_tick = src_tick && !restart && ((phase_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= '0;
    else if (restart)  phase_q <= '0;
    else if (src_tick) phase_q <= phase_q + DIV_W'(1);
  end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             intv_we,
  input  logic             cur_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick_main,
  input  logic             tick_alt,
  output ivt_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] intv_q,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire
);

  logic sel_tick;
  logic src_tick;
  logic div_tick;
  logic at_one;
  logic at_zero;

  always_comb begin
    unique case (ivt_src_e'(ctrl_q.src))
      SRC_OFF:  sel_tick = 1'b0;
      SRC_MAIN: sel_tick = tick_main;
      default:  sel_tick = tick_alt;
    endcase
    src_tick = sel_tick && ctrl_q.run;
  end

  ivt_prescaler #(.EXP_W(PSC_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ctrl_we),
    .src_tick (src_tick),
    .shift    (ctrl_q.psc),
    .div_tick (div_tick)
  );

  assign at_one  = (cur_q == CNT_W'(1));
  assign at_zero = (cur_q == '0);
  // A software write of the live count takes priority over the tick.
  assign expire  = div_tick && at_one && !cur_we;

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q     <= '0;
    else if (ctrl_we)                  ctrl_q     <= ivt_ctrl_t'(wdata[CTRL_W-1:0]);
    else if (expire && ctrl_q.single)  ctrl_q.run <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       intv_q <= '0;
    else if (intv_we) intv_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     cur_q <= '0;
    else if (cur_we)                cur_q <= wdata;
    else if (div_tick && !at_zero)  cur_q <= (at_one && ctrl_q.autorl) ? intv_q
                                                                        : cur_q - CNT_W'(1);
  end

endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-3:0] word_addr,
  input  logic [NUM_CH-1:0] mask_wdata,
  input  logic [NUM_CH-1:0] expire,
  input  ivt_ctrl_t         ch_ctrl [NUM_CH],
  input  logic [CNT_W-1:0]  ch_intv [NUM_CH],
  input  logic [CNT_W-1:0]  ch_cur  [NUM_CH],
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] intv_we,
  output logic [NUM_CH-1:0] cur_we,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] pend_q,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);

  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        fld;
  logic              glb_sel;
  logic [NUM_CH-1:0] clr_mask;

  assign slot    = word_addr[ADDR_W-3:2];
  assign fld     = word_addr[1:0];
  assign glb_sel = (slot == '0);

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      ctrl_we[ch] = bus_wr && (slot == SLOT_W'(ch + 1)) && (fld == FLD_CTRL);
      intv_we[ch] = bus_wr && (slot == SLOT_W'(ch + 1)) && (fld == FLD_INTV);
      cur_we[ch]  = bus_wr && (slot == SLOT_W'(ch + 1)) && (fld == FLD_CUR);
    end
  end

  assign clr_mask = (bus_wr && glb_sel && fld == GLB_STAT) ? mask_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                                   en_q <= '0;
    else if (bus_wr && glb_sel && fld == GLB_EN)  en_q <= mask_wdata;
  end

  // A hardware set wins over a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | expire;
  end

  always_comb begin
    rdata = '0;
    if (glb_sel) begin
      if (fld == GLB_EN)   rdata = CNT_W'(en_q);
      if (fld == GLB_STAT) rdata = CNT_W'(pend_q);
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (slot == SLOT_W'(ch + 1)) begin
        if (fld == FLD_CTRL) rdata = CNT_W'(ch_ctrl[ch]);
        if (fld == FLD_INTV) rdata = ch_intv[ch];
        if (fld == FLD_CUR)  rdata = ch_cur[ch];
      end
    end
  end

  assign irq = |(pend_q & en_q);

endmodule

// File: rtl/ivtimer.sv
module ivtimer
  import ivt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              tick_main,
  input  logic              tick_alt,
  output logic              irq
);

  localparam int SLOTS = 1 << (ADDR_W - 4);

  initial begin
    if (NUM_CH + 1 > SLOTS)  $error("ivtimer: address space too small for NUM_CH");
    if (CNT_W < CTRL_W)      $error("ivtimer: CNT_W narrower than control word");
    if (NUM_CH > CNT_W)      $error("ivtimer: NUM_CH wider than a register");
  end

  ivt_ctrl_t         ch_ctrl [NUM_CH];
  logic [CNT_W-1:0]  ch_intv [NUM_CH];
  logic [CNT_W-1:0]  ch_cur  [NUM_CH];
  logic [NUM_CH-1:0] ctrl_we, intv_we, cur_we;
  logic [NUM_CH-1:0] en_q, pend_q;
  logic [NUM_CH-1:0] expire_v, run_v, single_v;

  ivt_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .word_addr  (bus_addr[ADDR_W-1:2]),
    .mask_wdata (bus_wdata[NUM_CH-1:0]),
    .expire     (expire_v),
    .ch_ctrl    (ch_ctrl),
    .ch_intv    (ch_intv),
    .ch_cur     (ch_cur),
    .ctrl_we    (ctrl_we),
    .intv_we    (intv_we),
    .cur_we     (cur_we),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .rdata      (bus_rdata),
    .irq        (irq)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ivt_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ctrl_we[ch]),
      .intv_we   (intv_we[ch]),
      .cur_we    (cur_we[ch]),
      .wdata     (bus_wdata),
      .tick_main (tick_main),
      .tick_alt  (tick_alt),
      .ctrl_q    (ch_ctrl[ch]),
      .intv_q    (ch_intv[ch]),
      .cur_q     (ch_cur[ch]),
      .expire    (expire_v[ch])
    );
    assign run_v[ch]    = ch_ctrl[ch].run;
    assign single_v[ch] = ch_ctrl[ch].single;
  end

endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic              irq,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] en,
  input logic [NUM_CH-1:0] expire,
  input logic [NUM_CH-1:0] run,
  input logic [NUM_CH-1:0] single,
  input logic [NUM_CH-1:0] ctrl_we,
  input logic [NUM_CH-1:0] cur_we,
  input logic [CNT_W-1:0]  cur [NUM_CH]
);

  logic              stat_wr;
  logic [NUM_CH-1:0] wmask;

  assign stat_wr = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign wmask   = bus_wdata[NUM_CH-1:0];

  AST_PEND_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != '0) |-> (((pend & ~$past(pend)) & ~$past(expire)) == '0)); // R5

  AST_EXPIRY_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (expire != '0) |=> ((pend & $past(expire)) == $past(expire))); // R11

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((pend & $past(wmask & ~expire)) == '0)); // R11

  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((pend & $past(pend & ~wmask)) == $past(pend & ~wmask))); // R11

  AST_IRQ_NEEDS_ENABLED_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & en) != '0)); // R12

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !cur_we[i]) |=> (cur[i] == $past(cur[i]))); // R9

    AST_EXPIRY_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |-> run[i]); // R9

    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && single[i] && !ctrl_we[i]) |=> !run[i]); // R8
  end

endmodule

bind ivtimer ivtimer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .pend      (pend_q),
  .en        (en_q),
  .expire    (expire_v),
  .run       (run_v),
  .single    (single_v),
  .ctrl_we   (ctrl_we),
  .cur_we    (cur_we),
  .cur       (ch_cur)
);

// File: tb/ivtimer_test.sv
module ivtimer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 6;
  localparam int CNT_W      = 32;
  localparam int ADDR_W     = 8;
  localparam logic [7:0] A_EN   = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [CNT_W-1:0]  bus_wdata = '0;
  logic [CNT_W-1:0]  bus_rdata;
  logic              tick_main = 1'b1;
  logic              tick_alt = 1'b0;
  logic              irq;

  int     n_checks = 0;
  int     n_fail   = 0;
  longint cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivtimer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_main(tick_main),
    .tick_alt(tick_alt), .irq(irq)
  );

  function automatic logic [7:0] a_ctrl(int ch); return 8'(16 + 16*ch);     endfunction
  function automatic logic [7:0] a_intv(int ch); return 8'(16 + 16*ch + 4); endfunction
  function automatic logic [7:0] a_cur(int ch);  return 8'(16 + 16*ch + 8); endfunction

  function automatic logic [31:0] mk_ctrl(bit run, bit arl, int src, int p, bit single);
    return {24'b0, single, 3'(p), 2'(src), arl, run};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_pend(int ch, int limit, output longint at);
    at = -1;
    bus_addr = A_STAT;
    for (int c = 0; c < limit; c++) begin
      @(posedge clk);
      #1;
      if (bus_rdata[ch]) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, d1;
    longint start, t1, t2, t3;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(A_EN, d);   chk("R1 enable", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      rd(a_ctrl(ch), d); chk("R1 ctrl", d, 0);
      rd(a_intv(ch), d); chk("R1 intv", d, 0);
      rd(a_cur(ch), d);  chk("R1 cur", d, 0);
    end
    chk("R1 irq", 32'(irq), 0);

    // R2: unmapped offsets and ignored low address bits
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R2 unmapped 08", d, 0);
    rd(8'h1C, d); chk("R2 unmapped 1C", d, 0);
    rd(8'h70, d); chk("R2 unmapped 70", d, 0);
    rd(8'hFC, d); chk("R2 unmapped FC", d, 0);
    rd(A_EN, d);  chk("R2 unmapped write ignored", d, 0);
    wr(a_intv(3), 32'h1234_5678);
    rd(a_intv(3), d);      chk("R2 intv ch3", d, 32'h1234_5678);
    rd(a_intv(3) + 1, d);  chk("R2 low bits ignored", d, 32'h1234_5678);
    rd(a_intv(2), d);      chk("R2 neighbour untouched", d, 0);

    // R4 R5 R8: expiry timing over every channel and prescale exponent
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int p = 0; p < 8; p++) begin
        int n;
        n = 2 + ch % 3;
        wr(a_cur(ch), 32'(n));
        wr(a_ctrl(ch), mk_ctrl(1, 0, 1, p, 1));
        start = cyc;
        wait_pend(ch, (n << p) + 20, t1);
        chk("R4 expiry cycle", 32'(t1 - start), 32'(n << p));
        rd(A_STAT, d);     chk("R5 only own pending bit", d, 32'(1 << ch));
        rd(a_cur(ch), d);  chk("R5 count at zero", d, 0);
        rd(a_ctrl(ch), d); chk("R8 single clears run", 32'(d[0]), 0);
        wr(A_STAT, 32'(1 << ch));
        rd(A_STAT, d);     chk("R11 clear", d, 0);
      end
    end

    // R3 R6: auto-reload with a first timeout apart from the interval
    wr(a_cur(1), 3);
    wr(a_intv(1), 5);
    wr(a_ctrl(1), mk_ctrl(1, 1, 1, 1, 0));
    start = cyc;
    rd(a_ctrl(1), d); chk("R3 ctrl readback", d, mk_ctrl(1, 1, 1, 1, 0));
    wait_pend(1, 40, t1);
    chk("R6 first timeout", 32'(t1 - start), 6);
    rd(a_cur(1), d); chk("R6 reloaded", d, 5);
    wr(A_STAT, 32'h2);
    wait_pend(1, 40, t2);
    chk("R6 period", 32'(t2 - t1), 10);
    wr(A_STAT, 32'h2);
    wait_pend(1, 40, t3);
    chk("R6 period again", 32'(t3 - t2), 10);

    // R9: halt holds the count
    repeat (3) @(negedge clk);
    wr(a_ctrl(1), mk_ctrl(0, 1, 1, 1, 0));
    rd(a_cur(1), d1);
    repeat (20) @(negedge clk);
    rd(a_cur(1), d); chk("R9 halted count held", d, d1);
    wr(A_STAT, 32'h2);
    repeat (10) @(negedge clk);
    rd(A_STAT, d);   chk("R9 no expiry when halted", d, 0);

    // R7 R8: no reload in continuous mode
    wr(a_cur(2), 2);
    wr(a_intv(2), 9);
    wr(a_ctrl(2), mk_ctrl(1, 0, 1, 0, 0));
    start = cyc;
    wait_pend(2, 20, t1);
    chk("R7 expiry", 32'(t1 - start), 2);
    wr(A_STAT, 32'h4);
    repeat (40) @(negedge clk);
    rd(A_STAT, d);    chk("R7 no further pending", d, 0);
    rd(a_cur(2), d);  chk("R7 rests at zero", d, 0);
    rd(a_ctrl(2), d); chk("R8 continuous keeps run", 32'(d[0]), 1);
    wr(a_ctrl(2), 0);

    // R10: tick source selection
    wr(a_cur(4), 4);
    wr(a_ctrl(4), mk_ctrl(1, 0, 0, 0, 0));
    repeat (30) @(negedge clk);
    rd(a_cur(4), d); chk("R10 source off", d, 4);
    wr(a_ctrl(4), mk_ctrl(1, 0, 2, 0, 0));
    repeat (30) @(negedge clk);
    rd(a_cur(4), d); chk("R10 code 2 ignores main", d, 4);
    @(negedge clk); tick_alt = 1'b1;
    repeat (3) @(negedge clk); tick_alt = 1'b0;
    rd(a_cur(4), d); chk("R10 code 2 follows alt", d, 1);
    wr(a_ctrl(4), mk_ctrl(1, 0, 3, 0, 0));
    @(negedge clk); tick_alt = 1'b1;
    @(negedge clk); tick_alt = 1'b0;
    rd(A_STAT, d);   chk("R10 code 3 follows alt", d, 32'h10);
    wr(A_STAT, 32'h10);
    wr(a_ctrl(4), 0);

    // R12: interrupt gating
    wr(a_cur(5), 1);
    wr(a_ctrl(5), mk_ctrl(1, 0, 1, 0, 1));
    wait_pend(5, 10, t1);
    @(negedge clk);
    chk("R12 pending but disabled", 32'(irq), 0);
    wr(A_EN, 32'h20);
    chk("R12 pending and enabled", 32'(irq), 1);
    wr(A_EN, 32'h01);
    chk("R12 other channel enabled", 32'(irq), 0);
    wr(A_EN, 32'h20);
    wr(A_STAT, 32'h20);
    chk("R12 cleared", 32'(irq), 0);
    wr(A_EN, 0);

    // R11: clear lands on the expiring edge; the set wins
    wr(a_cur(0), 5);
    wr(a_ctrl(0), mk_ctrl(1, 0, 1, 0, 1));
    repeat (3) @(negedge clk);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R11 set wins over clear", d, 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R11 write zero keeps", d, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R11 write one clears", d, 0);

    summary();
    $finish;
  end

endmodule